// File: doc/BRIEF.md
# CABAC bin decode unit

This execution unit performs a single arithmetic-decoding step of a context-adaptive binary arithmetic decoder. A request carries two 64-bit operands. The interval operand holds the current range in its lower word and the current offset in its upper word. The context operand holds the probability state and the most-probable-symbol (MPS) value in its upper word, and a normalization shift amount in its lower word. Before any arithmetic, both range and offset are pre-normalized by that shift.

The unit looks up the least-probable-symbol (LPS) sub-range in a constant table. It splits the interval and decides which sub-interval the offset falls into. It returns a packed 64-bit result and the decoded bin. The lower result word packs the next probability state, the new MPS value and the new 9-bit range, left-aligned in bits 31:23. The upper result word is the new offset. The caller handles bitstream refill, renormalization of the returned range and context storage.

The result is computed combinationally and captured in one output register. A valid strobe marks the cycle in which the result appears.

Top module: `cabac_bin_unit`

## Requirements
- R1: The state is taken from `in_ctx[37:32]`, the MPS value from `in_ctx[40]` and the shift amount from `in_ctx[4:0]`. The range is `in_ival[31:0]` and the offset is `in_ival[63:32]`. No other context bit affects the result.
- R2: Range and offset are both shifted left by the shift amount (0 to 31) before use. Bits moved past bit 31 are lost.
- R3: The aligned LPS range is the standard H.264/AVC 64x4 LPS range table entry, shifted left by 23. The table is indexed by state and by bits 30:29 of the shifted range. On the LPS path, result bits 31:23 carry this entry.
- R4: The MPS range equals the shifted range ANDed with 0xFF800000, minus the aligned LPS range, modulo 2^32. On the MPS path, result bits 31:23 carry its bits 31:23.
- R5: When the shifted offset is below the MPS range (unsigned), the MPS path applies. Result bits 5:0 become min(state+1, 62) for states up to 62; state 63 stays 63. Result bit 8 becomes the MPS value, the upper result word is the shifted offset, and the bin equals the MPS value.
- R6: Otherwise, including the case where the offset equals the MPS range, the LPS path applies. Result bits 5:0 take the standard LPS next-state table entry, the upper result word is the shifted offset minus the MPS range, and the bin is the inverted MPS value.
- R7: On the LPS path, result bit 8 is the inverted MPS value when the state is 0, and the unchanged MPS value otherwise.
- R8: Result bits 7:6 and 22:9 are always zero.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. The result of that request is on `out_result`/`out_bin` at the same time.
- R10: While `in_valid` is low, `out_result` and `out_bin` keep their last values whatever the operand inputs do.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_result` and `out_bin` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; operands are sampled in this cycle |
| in_ival | input | 64 | Interval operand: offset in [63:32], range in [31:0] |
| in_ctx | input | 64 | Context operand: MPS in [40], state in [37:32], shift in [4:0] |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 64 | New offset in [63:32]; range [31:23], MPS [8], state [5:0] |
| out_bin | output | 1 | Decoded bin |

## Verification
The interval assertion assumes the operand is well formed: after the shift, the offset lies below the masked range. For such operands the returned offset must lie below the returned range on either path. Requests outside that condition are excluded by the assertion's antecedent, not forbidden. The sweep builds most ranges with a 9-bit leading value between 256 and 511, and places offsets just below, exactly at and just above the MPS split point, so most requests fall inside it. The shift sweep and the all-ones operands deliberately leave that condition, to exercise bit loss.

// File: rtl/cabac_pkg.sv
package cabac_pkg;

    localparam int WORD_W   = 32;
    localparam int STATE_W  = 6;
    localparam int POS_W    = 5;
    localparam int RNG_W    = 9;
    localparam int QIDX_W   = 2;
    localparam int LPS_W    = 8;
    localparam int MPS_BIT  = 8;
    localparam int ALIGN    = WORD_W - RNG_W;
    localparam int QIDX_LSB = WORD_W - 1 - QIDX_W;
    localparam int NSTATES  = 2 ** STATE_W;
    localparam int NQ       = 2 ** QIDX_W;
    localparam int TOP_MPS  = NSTATES - 2;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [STATE_W-1:0] state_t;
    typedef logic [POS_W-1:0]   pos_t;
    typedef logic [0:NQ-1][LPS_W-1:0] lps_row_t;

    localparam word_t RNG_MASK = {{RNG_W{1'b1}}, {ALIGN{1'b0}}};

    typedef enum logic {
        PATH_MPS = 1'b0,
        PATH_LPS = 1'b1
    } path_e;

    typedef struct packed {
        state_t state;
        logic   mps;
        word_t  rng;
        word_t  off;
    } norm_t;

    typedef struct packed {
        word_t rlps;
        word_t rmps;
    } split_t;

    typedef struct packed {
        word_t off;
        word_t ctx;
        logic  bin;
    } result_t;

    localparam state_t NEXT_LPS_TAB [NSTATES] = '{
        6'd0,  6'd0,  6'd1,  6'd2,  6'd2,  6'd4,  6'd4,  6'd5,
        6'd6,  6'd7,  6'd8,  6'd9,  6'd9,  6'd11, 6'd11, 6'd12,
        6'd13, 6'd13, 6'd15, 6'd15, 6'd16, 6'd16, 6'd18, 6'd18,
        6'd19, 6'd19, 6'd21, 6'd21, 6'd22, 6'd22, 6'd23, 6'd24,
        6'd24, 6'd25, 6'd26, 6'd26, 6'd27, 6'd27, 6'd28, 6'd29,
        6'd29, 6'd30, 6'd30, 6'd30, 6'd31, 6'd32, 6'd32, 6'd33,
        6'd33, 6'd33, 6'd34, 6'd34, 6'd35, 6'd35, 6'd35, 6'd36,
        6'd36, 6'd36, 6'd37, 6'd37, 6'd37, 6'd38, 6'd38, 6'd63
    };

    function automatic state_t next_mps(input state_t s);
        if (int'(s) >= TOP_MPS)
            return s;
        return s + state_t'(1);
    endfunction

    function automatic lps_row_t lps_row(input state_t s);
        case (s)
            6'd0:  return {8'd128, 8'd176, 8'd208, 8'd240};
            6'd1:  return {8'd128, 8'd167, 8'd197, 8'd227};
            6'd2:  return {8'd128, 8'd158, 8'd187, 8'd216};
            6'd3:  return {8'd123, 8'd150, 8'd178, 8'd205};
            6'd4:  return {8'd116, 8'd142, 8'd169, 8'd195};
            6'd5:  return {8'd111, 8'd135, 8'd160, 8'd185};
            6'd6:  return {8'd105, 8'd128, 8'd152, 8'd175};
            6'd7:  return {8'd100, 8'd122, 8'd144, 8'd166};
            6'd8:  return {8'd95,  8'd116, 8'd137, 8'd158};
            6'd9:  return {8'd90,  8'd110, 8'd130, 8'd150};
            6'd10: return {8'd85,  8'd104, 8'd123, 8'd142};
            6'd11: return {8'd81,  8'd99,  8'd117, 8'd135};
            6'd12: return {8'd77,  8'd94,  8'd111, 8'd128};
            6'd13: return {8'd73,  8'd89,  8'd105, 8'd122};
            6'd14: return {8'd69,  8'd85,  8'd100, 8'd116};
            6'd15: return {8'd66,  8'd80,  8'd95,  8'd110};
            6'd16: return {8'd62,  8'd76,  8'd90,  8'd104};
            6'd17: return {8'd59,  8'd72,  8'd86,  8'd99};
            6'd18: return {8'd56,  8'd69,  8'd81,  8'd94};
            6'd19: return {8'd53,  8'd65,  8'd77,  8'd89};
            6'd20: return {8'd51,  8'd62,  8'd73,  8'd85};
            6'd21: return {8'd48,  8'd59,  8'd69,  8'd80};
            6'd22: return {8'd46,  8'd56,  8'd66,  8'd76};
            6'd23: return {8'd43,  8'd53,  8'd63,  8'd72};
            6'd24: return {8'd41,  8'd50,  8'd59,  8'd69};
            6'd25: return {8'd39,  8'd48,  8'd56,  8'd65};
            6'd26: return {8'd37,  8'd45,  8'd54,  8'd62};
            6'd27: return {8'd35,  8'd43,  8'd51,  8'd59};
            6'd28: return {8'd33,  8'd41,  8'd48,  8'd56};
            6'd29: return {8'd32,  8'd39,  8'd46,  8'd53};
            6'd30: return {8'd30,  8'd37,  8'd43,  8'd50};
            6'd31: return {8'd29,  8'd35,  8'd41,  8'd48};
            6'd32: return {8'd27,  8'd33,  8'd39,  8'd45};
            6'd33: return {8'd26,  8'd31,  8'd37,  8'd43};
            6'd34: return {8'd24,  8'd30,  8'd35,  8'd41};
            6'd35: return {8'd23,  8'd28,  8'd33,  8'd39};
            6'd36: return {8'd22,  8'd27,  8'd32,  8'd37};
            6'd37: return {8'd21,  8'd26,  8'd30,  8'd35};
            6'd38: return {8'd20,  8'd24,  8'd29,  8'd33};
            6'd39: return {8'd19,  8'd23,  8'd27,  8'd31};
            6'd40: return {8'd18,  8'd22,  8'd26,  8'd30};
            6'd41: return {8'd17,  8'd21,  8'd25,  8'd28};
            6'd42: return {8'd16,  8'd20,  8'd23,  8'd27};
            6'd43: return {8'd15,  8'd19,  8'd22,  8'd25};
            6'd44: return {8'd14,  8'd18,  8'd21,  8'd24};
            6'd45: return {8'd14,  8'd17,  8'd20,  8'd23};
            6'd46: return {8'd13,  8'd16,  8'd19,  8'd22};
            6'd47: return {8'd12,  8'd15,  8'd18,  8'd21};
            6'd48: return {8'd12,  8'd14,  8'd17,  8'd20};
            6'd49: return {8'd11,  8'd14,  8'd16,  8'd19};
            6'd50: return {8'd11,  8'd13,  8'd15,  8'd18};
            6'd51: return {8'd10,  8'd12,  8'd15,  8'd17};
            6'd52: return {8'd10,  8'd12,  8'd14,  8'd16};
            6'd53: return {8'd9,   8'd11,  8'd13,  8'd15};
            6'd54: return {8'd9,   8'd11,  8'd12,  8'd14};
            6'd55: return {8'd8,   8'd10,  8'd12,  8'd14};
            6'd56: return {8'd8,   8'd9,   8'd11,  8'd13};
            6'd57: return {8'd7,   8'd9,   8'd11,  8'd12};
            6'd58: return {8'd7,   8'd9,   8'd10,  8'd12};
            6'd59: return {8'd7,   8'd8,   8'd10,  8'd11};
            6'd60: return {8'd6,   8'd8,   8'd9,   8'd11};
            6'd61: return {8'd6,   8'd7,   8'd9,   8'd10};
            6'd62: return {8'd6,   8'd7,   8'd8,   8'd9};
            default: return {8'd2, 8'd2,   8'd2,   8'd2};
        endcase
    endfunction

endpackage

// File: rtl/cabac_unpack.sv
module cabac_unpack
    import cabac_pkg::*;
(
    input  logic [2*WORD_W-1:0] ival,
    input  logic [2*WORD_W-1:0] ctx,
    output norm_t               norm
);
    word_t ctx_hi;
    word_t ctx_lo;
    pos_t  shamt;
    logic  unused_ctx_bits;

    assign ctx_hi = ctx[2*WORD_W-1:WORD_W];
    assign ctx_lo = ctx[WORD_W-1:0];
    assign shamt  = ctx_lo[POS_W-1:0];

    assign unused_ctx_bits = ^{ctx_hi[WORD_W-1:MPS_BIT+1],
                               ctx_hi[MPS_BIT-1:STATE_W],
                               ctx_lo[WORD_W-1:POS_W]};

    always_comb begin
        norm.state = ctx_hi[STATE_W-1:0];
        norm.mps   = ctx_hi[MPS_BIT];
        norm.rng   = ival[WORD_W-1:0] << shamt;
        norm.off   = ival[2*WORD_W-1:WORD_W] << shamt;
    end
endmodule

// File: rtl/cabac_split.sv
module cabac_split
    import cabac_pkg::*;
(
    input  norm_t  norm,
    output split_t split
);
    lps_row_t              row;
    logic [QIDX_W-1:0]     qidx;

    assign row  = lps_row(norm.state);
    assign qidx = norm.rng[QIDX_LSB +: QIDX_W];

    always_comb begin
        split.rlps = word_t'(row[qidx]) << ALIGN;
        split.rmps = (norm.rng & RNG_MASK) - split.rlps;
    end
endmodule

// File: rtl/cabac_pack.sv
module cabac_pack
    import cabac_pkg::*;
(
    input  norm_t   norm,
    input  split_t  split,
    output result_t res,
    output path_e   path
);
    logic unused_low_bits;

    assign unused_low_bits = ^{split.rlps[ALIGN-1:0], split.rmps[ALIGN-1:0]};
    assign path = (norm.off < split.rmps) ? PATH_MPS : PATH_LPS;

    always_comb begin
        res.ctx = '0;
        if (path == PATH_MPS) begin
            res.ctx[STATE_W-1:0]     = next_mps(norm.state);
            res.ctx[MPS_BIT]         = norm.mps;
            res.ctx[WORD_W-1:ALIGN]  = split.rmps[WORD_W-1:ALIGN];
            res.off                  = norm.off;
            res.bin                  = norm.mps;
        end else begin
            res.ctx[STATE_W-1:0]     = NEXT_LPS_TAB[norm.state];
            res.ctx[MPS_BIT]         = (norm.state == '0) ? ~norm.mps : norm.mps;
            res.ctx[WORD_W-1:ALIGN]  = split.rlps[WORD_W-1:ALIGN];
            res.off                  = norm.off - split.rmps;
            res.bin                  = ~norm.mps;
        end
    end
endmodule

// File: rtl/cabac_bin_unit.sv
module cabac_bin_unit
    import cabac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2*WORD_W-1:0] in_ival,
    input  logic [2*WORD_W-1:0] in_ctx,
    output logic                out_valid,
    output logic [2*WORD_W-1:0] out_result,
    output logic                out_bin
);
    norm_t   norm;
    split_t  split;
    result_t res;
    path_e   path;
    result_t res_q;
    logic    well_formed;

    cabac_unpack u_unpack (.ival(in_ival), .ctx(in_ctx), .norm(norm));
    cabac_split  u_split  (.norm(norm), .split(split));
    cabac_pack   u_pack   (.norm(norm), .split(split), .res(res), .path(path));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                res_q <= res;
        end
    end

    assign out_result = {res_q.off, res_q.ctx};
    assign out_bin    = res_q.bin;

    assign well_formed = norm.off < (norm.rng & RNG_MASK);

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_result) && $stable(out_bin)));

    assert_zero_fields_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_result[MPS_BIT-1:STATE_W] == '0 &&
                       out_result[ALIGN-1:MPS_BIT+1] == '0));

    assert_offset_in_interval_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && well_formed) |=>
        (out_result[2*WORD_W-1:WORD_W] <
         {out_result[WORD_W-1:ALIGN], {ALIGN{1'b0}}}));

    assert_bin_matches_path_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && path == PATH_MPS) |=> (out_bin == out_result[MPS_BIT]));
endmodule

// File: tb/tb_cabac_bin_unit.sv
`timescale 1ns/1ps
module tb_cabac_bin_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_ival = '0;
    logic [63:0] in_ctx = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_bin;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cabac_bin_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ival(in_ival),
        .in_ctx(in_ctx), .out_valid(out_valid), .out_result(out_result),
        .out_bin(out_bin)
    );

    int rlps_tb [64][4] = '{
        '{128,176,208,240}, '{128,167,197,227}, '{128,158,187,216}, '{123,150,178,205},
        '{116,142,169,195}, '{111,135,160,185}, '{105,128,152,175}, '{100,122,144,166},
        '{95,116,137,158},  '{90,110,130,150},  '{85,104,123,142},  '{81,99,117,135},
        '{77,94,111,128},   '{73,89,105,122},   '{69,85,100,116},   '{66,80,95,110},
        '{62,76,90,104},    '{59,72,86,99},     '{56,69,81,94},     '{53,65,77,89},
        '{51,62,73,85},     '{48,59,69,80},     '{46,56,66,76},     '{43,53,63,72},
        '{41,50,59,69},     '{39,48,56,65},     '{37,45,54,62},     '{35,43,51,59},
        '{33,41,48,56},     '{32,39,46,53},     '{30,37,43,50},     '{29,35,41,48},
        '{27,33,39,45},     '{26,31,37,43},     '{24,30,35,41},     '{23,28,33,39},
        '{22,27,32,37},     '{21,26,30,35},     '{20,24,29,33},     '{19,23,27,31},
        '{18,22,26,30},     '{17,21,25,28},     '{16,20,23,27},     '{15,19,22,25},
        '{14,18,21,24},     '{14,17,20,23},     '{13,16,19,22},     '{12,15,18,21},
        '{12,14,17,20},     '{11,14,16,19},     '{11,13,15,18},     '{10,12,15,17},
        '{10,12,14,16},     '{9,11,13,15},      '{9,11,12,14},      '{8,10,12,14},
        '{8,9,11,13},       '{7,9,11,12},       '{7,9,10,12},       '{7,8,10,11},
        '{6,8,9,11},        '{6,7,9,10},        '{6,7,8,9},         '{2,2,2,2}
    };

    int nxl_tb [64] = '{
        0,0,1,2,2,4,4,5,6,7,8,9,9,11,11,12,
        13,13,15,15,16,16,18,18,19,19,21,21,22,22,23,24,
        24,25,26,26,27,27,28,29,29,30,30,30,31,32,32,33,
        33,33,34,34,35,35,35,36,36,36,37,37,37,38,38,63
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [63:0] iv, input logic [63:0] cx,
                         output logic [63:0] res, output logic b, output bit lps);
        int s;
        logic m;
        int p;
        logic [31:0] rng, off, rl, rm, lo, hi;
        s   = int'(cx[37:32]);
        m   = cx[40];
        p   = int'(cx[4:0]);
        rng = iv[31:0] << p;
        off = iv[63:32] << p;
        rl  = 32'(rlps_tb[s][int'(rng[30:29])]) * 32'h0080_0000;
        rm  = (rng & 32'hFF80_0000) - rl;
        lps = !(off < rm);
        if (!lps) begin
            lo = {rm[31:23], 14'd0, m, 2'd0, 6'((s < 62) ? s + 1 : s)};
            hi = off;
            b  = m;
        end else begin
            lo = {rl[31:23], 14'd0, ((s == 0) ? ~m : m), 2'd0, 6'(nxl_tb[s])};
            hi = off - rm;
            b  = ~m;
        end
        res = {hi, lo};
    endtask

    // One request: drive at a falling edge, captured at the next rising edge,
    // sampled at the falling edge after it.
    task automatic xact(input logic [63:0] iv, input logic [63:0] cx, input string tag);
        logic [63:0] e;
        logic eb;
        bit lps;
        string tp, t8, tr;
        @(negedge clk);
        in_valid = 1'b1;
        in_ival  = iv;
        in_ctx   = cx;
        model(iv, cx, e, eb, lps);
        @(negedge clk);
        tp = lps ? "R6" : "R5";
        t8 = lps ? "R7" : "R5";
        tr = lps ? "R3" : "R4";
        if (tag != "") begin
            tp = tag; t8 = tag; tr = tag;
        end
        chk(out_valid == 1'b1, "R9", 64'(out_valid), 64'd1);
        chk(out_bin == eb, tp, 64'(out_bin), 64'(eb));
        chk(out_result[5:0] == e[5:0], tp, 64'(out_result[5:0]), 64'(e[5:0]));
        chk(out_result[8] == e[8], t8, 64'(out_result[8]), 64'(e[8]));
        chk(out_result[31:23] == e[31:23], tr, 64'(out_result[31:23]), 64'(e[31:23]));
        chk(out_result[63:32] == e[63:32], tp, 64'(out_result[63:32]), 64'(e[63:32]));
        chk(out_result[7:6] == 2'b00 && out_result[22:9] == 14'd0, "R8",
            out_result, e);
    endtask

    function automatic logic [63:0] mk_ctx(input int s, input bit m, input int p,
                                           input logic [22:0] junk);
        return {junk, m, 2'b11, 6'(s), 27'(junk) ^ 27'h5A5_A5A5, 5'(p)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] saved;
        logic        saved_bin;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(out_valid == 1'b0, "R11", 64'(out_valid), 64'd0);
        chk(out_result == 64'd0, "R11", out_result, 64'd0);
        chk(out_bin == 1'b0, "R11", 64'(out_bin), 64'd0);
        rst = 1'b0;

        // Main sweep: every state, both MPS values, every quarter index,
        // offsets below, at and above the split point.
        for (int s = 0; s < 64; s++) begin
            for (int m = 0; m < 2; m++) begin
                for (int q = 0; q < 4; q++) begin
                    for (int k = 0; k < 4; k++) begin
                        logic [8:0]  r9;
                        logic [31:0] big_r, rl, rm, o;
                        logic [22:0] junk;
                        int p;
                        r9    = 9'(256 + q * 64 + s);
                        junk  = 23'(s * 4099 + q * 77 + k);
                        big_r = {r9, junk};
                        p     = (s * 5 + q + k) % 24;
                        rl    = 32'(rlps_tb[s][q]) << 23;
                        rm    = (big_r & 32'hFF80_0000) - rl;
                        case (k)
                            0: o = rm - 32'd1;
                            1: o = rm;
                            2: o = (big_r & 32'hFF80_0000) - 32'd1;
                            default: o = rm + 32'd1;
                        endcase
                        xact({o >> p, big_r >> p}, mk_ctx(s, m[0], p, junk), "");
                    end
                end
            end
        end

        // R2: every shift amount, including 31, with bits lost off the top
        for (int p = 0; p < 32; p++) begin
            xact({32'h0000_0001, 32'h0000_0001}, mk_ctx(p % 64, 1'b0, p, 23'h1), "R2");
            xact({32'hFFFF_FFFF, 32'hFFFF_FFFF}, mk_ctx(0, 1'b1, p, 23'h2), "R2");
            xact({32'h1234_5678 >> p, 32'hC000_0000 >> p},
                 mk_ctx(0, 1'b0, p, 23'h3), "R2");
        end

        // R1: only the named context bits matter
        xact({32'h3000_0000, 32'hE000_0000}, {32'hFFFF_FEC5, 32'hFFFF_FFE0}, "R1");
        xact({32'h3000_0000, 32'hE000_0000}, {32'h0000_0105, 32'h0000_0000}, "R1");

        // R10: idle cycle holds the result; R9: no valid without a request
        saved     = out_result;
        saved_bin = out_bin;
        @(negedge clk);
        in_valid = 1'b0;
        in_ival  = 64'h0123_4567_89AB_CDEF;
        in_ctx   = 64'h0000_0100_0000_0003;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
        chk(out_result == saved, "R10", out_result, saved);
        chk(out_bin == saved_bin, "R10", 64'(out_bin), 64'(saved_bin));

        // R11: reset during a request clears the outputs
        xact({32'h0, 32'h8000_0000}, mk_ctx(10, 1'b1, 0, 23'h0), "");
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", 64'(out_valid), 64'd0);
        chk(out_result == 64'd0, "R11", out_result, 64'd0);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule